// File: doc/BRIEF.md
# Type 1 to Type 0 Configuration Translator

This block sits on the downstream path of a bridge between an upstream link and a secondary parallel bus. Each configuration request arriving from upstream carries a bus number, a device number, a function number and a register offset. The block compares the bus number against the bridge's secondary and subordinate bus numbers. From that comparison it decides whether the secondary bus sees one of these:

- a type 0 configuration cycle, with a one-hot IDSEL line on AD[31:16];
- a special cycle;
- an unchanged type 1 cycle, for a bus further downstream;
- nothing at all.

Configuration cycles started by another master on the secondary side are filtered out, and so are device ID messages. The bridge never claims either of them.

The decision is registered, so it appears one clock after the request strobe. A downstream sequencer uses the cycle kind, the IDSEL vector and the claim flag to run the bus. The electrical sequencing of that bus is not part of this block.

Top module: `cfg_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_claim`, `out_kind` and `out_idsel` are all zero.
- R2: `out_valid` equals `req_valid` of the previous clock. When `out_valid` is low, `out_kind`, `out_idsel` and `out_claim` are zero.
- R3: A claimable request whose bus equals `sec_bus` and whose device number N is 0 to 15 gives `out_kind` = 1 (type 0) and `out_claim` = 1. `out_idsel` has exactly bit N set, which is AD[16+N].
- R4: A claimable request to `sec_bus` with device 16 to 30, or with device 31 but not the special encoding, gives `out_kind` = 1 with `out_idsel` all zero and `out_claim` = 1.
- R5: A claimable request to `sec_bus` with device 31, function 7 and register 0 gives `out_kind` = 2 (special cycle) with `out_idsel` zero and `out_claim` = 1.
- R6: A claimable request whose bus is above `sec_bus` and at or below `sub_bus` gives `out_kind` = 3 (type 1 forwarded) with `out_idsel` zero and `out_claim` = 1.
- R7: A request whose bus is below `sec_bus` or above `sub_bus` gives `out_kind` = 0 and `out_claim` = 0.
- R8: A request with `req_from_sec` = 1 (a configuration cycle seen on the secondary bus from another master) is never claimed. It gives `out_kind` = 0 and `out_idsel` zero, whatever its fields hold.
- R9: A request with `req_is_dim` = 1 (a device ID message) is never claimed. It gives `out_kind` = 0 and `out_idsel` zero, whatever its fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_from_sec | input | 1 | Request was started by a master on the secondary bus |
| req_is_dim | input | 1 | Request is a device ID message |
| req_bus | input | BUS_W | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_reg | input | REG_W | Register offset |
| sec_bus | input | BUS_W | Secondary bus number |
| sub_bus | input | BUS_W | Subordinate bus number |
| out_valid | output | 1 | Decision valid |
| out_kind | output | 2 | 0 none, 1 type 0, 2 special, 3 type 1 forward |
| out_idsel | output | 16 | IDSEL vector for AD[31:16] |
| out_claim | output | 1 | Bridge claims the request |

## Verification
Filtering and decoding can both apply in the same cycle. A request can carry the exact special-cycle encoding aimed at the secondary bus number while also being flagged as secondary-initiated or as a device ID message. The bench sends such requests, including one with device 0, and requires the filter to win: no claim, kind 0, no IDSEL. A second overlap occurs when the secondary and subordinate numbers are equal, so that the local and forward ranges touch. The bench checks that the local decode is taken there and that the next bus number up is rejected.

// File: rtl/cfg_xlate.sv
module cfg_xlate #(
  parameter int BUS_W = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_from_sec,
  input  logic             req_is_dim,
  input  logic [BUS_W-1:0] req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_func,
  input  logic [REG_W-1:0] req_reg,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output logic             out_valid,
  output logic [1:0]       out_kind,
  output logic [15:0]      out_idsel,
  output logic             out_claim
);
  localparam int IDSEL_W = 16;
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_T0   = 2'd1;
  localparam logic [1:0] K_SPC  = 2'd2;
  localparam logic [1:0] K_FWD  = 2'd3;

  logic filtered, local_hit, fwd_hit, spc_hit;
  logic [1:0] kind_n;
  logic [IDSEL_W-1:0] idsel_n;

  assign filtered  = req_from_sec | req_is_dim;
  assign local_hit = req_bus == sec_bus;
  assign fwd_hit   = (req_bus > sec_bus) && (req_bus <= sub_bus);
  assign spc_hit   = (req_dev == 5'd31) && (req_func == 3'd7) && (req_reg == '0);

  always_comb begin
    kind_n  = K_NONE;
    idsel_n = '0;
    if (req_valid && !filtered) begin
      if (local_hit) begin
        if (spc_hit) kind_n = K_SPC;
        else begin
          kind_n = K_T0;
          if (!req_dev[4]) idsel_n = IDSEL_W'(1) << req_dev[3:0];
        end
      end else if (fwd_hit) kind_n = K_FWD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= K_NONE;
      out_idsel <= '0;
      out_claim <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_kind  <= kind_n;
      out_idsel <= idsel_n;
      out_claim <= kind_n != K_NONE;
    end
  end
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_from_sec,
  input logic        req_is_dim,
  input logic        out_valid,
  input logic [1:0]  out_kind,
  input logic [15:0] out_idsel,
  input logic        out_claim
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_claim && out_kind == 2'd0 && out_idsel == '0));
  // R3
  idsel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_idsel));
  // R5
  spc_no_idsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind != 2'd1) |-> out_idsel == '0);
  // R8
  sec_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_from_sec) |=> !out_claim);
  // R9
  dim_unclaimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_dim) |=> !out_claim);
endmodule

bind cfg_xlate cfg_xlate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .req_from_sec(req_from_sec), .req_is_dim(req_is_dim),
  .out_valid(out_valid), .out_kind(out_kind),
  .out_idsel(out_idsel), .out_claim(out_claim)
);

// File: tb/test_cfg_xlate.sv
module test_cfg_xlate;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_from_sec = 0, req_is_dim = 0;
  logic [7:0] req_bus = 0, sec_bus = 0, sub_bus = 0, req_reg = 0;
  logic [4:0] req_dev = 0;
  logic [2:0] req_func = 0;
  logic out_valid, out_claim;
  logic [1:0] out_kind;
  logic [15:0] out_idsel;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_xlate i_cfg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_from_sec(req_from_sec),
    .req_is_dim(req_is_dim), .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
    .req_reg(req_reg), .sec_bus(sec_bus), .sub_bus(sub_bus), .out_valid(out_valid),
    .out_kind(out_kind), .out_idsel(out_idsel), .out_claim(out_claim));

  task automatic check(string req, logic v, logic [1:0] k, logic [15:0] id, logic c);
    total++;
    if (out_valid !== v || out_kind !== k || out_idsel !== id || out_claim !== c) begin
      bad++;
      $display("FAIL %s: got v=%b k=%0d id=%h c=%b exp v=%b k=%0d id=%h c=%b",
               req, out_valid, out_kind, out_idsel, out_claim, v, k, id, c);
    end
  endtask

  task automatic send(logic fs, logic dim, logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [7:0] r);
    @(negedge clk);
    req_valid = 1; req_from_sec = fs; req_is_dim = dim;
    req_bus = b; req_dev = d; req_func = f; req_reg = r;
    @(negedge clk);
    req_valid = 0; req_from_sec = 0; req_is_dim = 0;
  endtask

  task automatic t_reset;
    check("R1 in reset", 0, 0, 0, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 0, 0, 0, 0);
  endtask

  task automatic t_low_devs;
    for (int d = 0; d < 16; d++) begin
      send(0, 0, 8'd4, 5'(d), 3'(d % 8), 8'h10);
      check("R3 type0 idsel", 1, 1, 16'(1) << d, 1);
    end
    @(negedge clk);
    check("R2 idle after request", 0, 0, 0, 0);
  endtask

  task automatic t_high_devs;
    for (int d = 16; d < 31; d++) begin
      send(0, 0, 8'd4, 5'(d), 3'd0, 8'h00);
      check("R4 high device", 1, 1, 0, 1);
    end
    send(0, 0, 8'd4, 5'd31, 3'd6, 8'h00);
    check("R4 dev31 func6", 1, 1, 0, 1);
    send(0, 0, 8'd4, 5'd31, 3'd7, 8'h04);
    check("R4 dev31 reg4", 1, 1, 0, 1);
  endtask

  task automatic t_special;
    send(0, 0, 8'd4, 5'd31, 3'd7, 8'h00);
    check("R5 special", 1, 2, 0, 1);
  endtask

  task automatic t_forward;
    send(0, 0, 8'd5, 5'd0, 3'd0, 8'h00);
    check("R6 forward low edge", 1, 3, 0, 1);
    send(0, 0, 8'd9, 5'd31, 3'd7, 8'h00);
    check("R6 forward at sub", 1, 3, 0, 1);
  endtask

  task automatic t_outside;
    send(0, 0, 8'd3, 5'd2, 3'd0, 8'h00);
    check("R7 below sec", 1, 0, 0, 0);
    send(0, 0, 8'd10, 5'd2, 3'd0, 8'h00);
    check("R7 above sub", 1, 0, 0, 0);
  endtask

  task automatic t_filters;
    send(1, 0, 8'd4, 5'd31, 3'd7, 8'h00);
    check("R8 secondary special", 1, 0, 0, 0);
    send(1, 0, 8'd4, 5'd0, 3'd0, 8'h00);
    check("R8 secondary dev0", 1, 0, 0, 0);
    send(1, 0, 8'd6, 5'd0, 3'd0, 8'h00);
    check("R8 secondary forward range", 1, 0, 0, 0);
    send(0, 1, 8'd4, 5'd3, 3'd0, 8'h00);
    check("R9 dim dev3", 1, 0, 0, 0);
    send(0, 1, 8'd7, 5'd31, 3'd7, 8'h00);
    check("R9 dim forward range", 1, 0, 0, 0);
  endtask

  task automatic t_equal_bounds;
    @(negedge clk); sec_bus = 8'd12; sub_bus = 8'd12;
    send(0, 0, 8'd12, 5'd15, 3'd0, 8'h00);
    check("R3 sec equals sub", 1, 1, 16'h8000, 1);
    send(0, 0, 8'd13, 5'd0, 3'd0, 8'h00);
    check("R7 just above sub", 1, 0, 0, 0);
    @(negedge clk); sec_bus = 8'd4; sub_bus = 8'd9;
  endtask

  initial begin
    sec_bus = 8'd4; sub_bus = 8'd9;
    repeat (3) @(negedge clk);
    t_reset();
    t_low_devs();
    t_high_devs();
    t_special();
    t_forward();
    t_outside();
    t_filters();
    t_equal_bounds();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule